// File: doc/BRIEF.md
# Register Rename Map Unit

This unit removes false (write-after-read and write-after-write) register dependencies by giving every newly written architectural register a fresh physical register from a larger pool. Each cycle a decoder may present one instruction: two architectural source ids and, optionally, one architectural destination id. In the same cycle the unit returns the physical ids currently bound to both sources and, for a writing instruction, the physical id at the head of a free pool. On acceptance the binding of the destination is replaced by that new id, so the next instruction that reads it sees the new physical register.

Physical ids return to the pool through a separate release port, which a retirement stage drives with ids that are no longer referenced. The pool is a first-in first-out queue, so ids come back into use in the order in which they were released. After reset architectural register k is bound to physical register k and the remaining physical ids wait in the pool in ascending order.

Both the rename port and the release port follow valid/ready rules: a transfer takes place in a cycle where valid and ready are both high, ready does not depend on valid, and a held request may change its fields while ready is low. The rename outputs are combinational and are meaningful only in a cycle where the rename transfer takes place.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register k is bound to physical register k for every k below NUM_LOG, and the pool holds physical ids NUM_LOG up to NUM_PHYS-1, handed out in ascending order.
- R2: In a cycle with an accepted rename, `ren_psrc0` and `ren_psrc1` equal the current bindings of `ren_src0` and `ren_src1`.
- R3: In a cycle with an accepted writing rename (`ren_has_dst` = 1), `ren_pdst` is the id at the head of the pool; successive writing renames receive pool ids in queue order, even when they target the same architectural register.
- R4: After an accepted writing rename, the architectural destination is bound to the id returned in `ren_pdst`, visible to reads from the next cycle on.
- R5: When an instruction reads and writes the same architectural register, its source returns the binding from before this instruction.
- R6: `stall` is 1 exactly when the pool is empty; then `ren_ready` is 0 for a writing request, and no binding and no pool content changes.
- R7: `free_ready` is 0 exactly when the pool holds NUM_PHYS-NUM_LOG ids (as it does after reset); an accepted release appends `free_pid` at the tail of the pool.
- R8: A release and a writing rename in the same cycle are both carried out: the rename takes the old head and the released id joins the tail.
- R9: A rename with `ren_has_dst` = 0 is always ready, takes no id from the pool and changes no binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_src0 | input | LW | First architectural source id |
| ren_src1 | input | LW | Second architectural source id |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_dst | input | LW | Architectural destination id |
| ren_psrc0 | output | PW | Physical id bound to ren_src0 |
| ren_psrc1 | output | PW | Physical id bound to ren_src1 |
| ren_pdst | output | PW | Newly allocated physical destination id |
| free_valid | input | 1 | Release request present |
| free_ready | output | 1 | Pool can take a released id |
| free_pid | input | PW | Physical id being released |
| stall | output | 1 | Pool is empty |

## Verification
The assertions take for granted that a released id is one that was handed out before, is released at most once per allocation, and is not still bound to an architectural register, so the pool never holds duplicates and can never be asked to exceed its capacity. The stimulus keeps to this by releasing only ids that lost their binding through a later rename of the same architectural register, in the order they lost it. Random traffic mixes reading-only and writing renames with releases so that the pool runs empty and full repeatedly, while directed sequences cover the reset bindings, same-register read-and-write, draining the pool and a release in the same cycle as an allocation.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Default sizing for the rename unit
  localparam int unsigned DEF_NUM_LOG  = 16;
  localparam int unsigned DEF_NUM_PHYS = 32;

  // Width of a counter or pointer able to index n entries
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  localparam int unsigned LW = rn_pkg::idx_bits(NUM_LOG),
  localparam int unsigned PW = rn_pkg::idx_bits(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_idx0,
  input  logic [LW-1:0] rd_idx1,
  output logic [PW-1:0] rd_pid0,
  output logic [PW-1:0] rd_pid1,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [PW-1:0] wr_pid
);
  logic [PW-1:0] bind_q [NUM_LOG];

  // One register per architectural id, reset to the identity binding
  for (genvar k = 0; k < NUM_LOG; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        bind_q[k] <= PW'(k);
      else if (wr_en && (wr_idx == LW'(k)))
        bind_q[k] <= wr_pid;
    end
  end

  // Reads see the state before this cycle's write
  assign rd_pid0 = bind_q[rd_idx0];
  assign rd_pid1 = bind_q[rd_idx1];

  AST_MAP_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bind_q[$past(wr_idx)] == $past(wr_pid)); // R4
endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG,
  localparam int unsigned PW = rn_pkg::idx_bits(NUM_PHYS),
  localparam int unsigned AW = rn_pkg::idx_bits(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_pid_i,
  output logic [PW-1:0] head_pid_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Slots start out holding the spare physical ids in ascending order
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[k] <= PW'(NUM_LOG + k);
      else if (push_i && (wr_ptr_q == AW'(k)))
        slot_q[k] <= push_pid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= CW'(DEPTH);
    end else begin
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_pid_o = slot_q[rd_ptr_q];
  assign empty_o    = (count_q == '0);
  assign full_o     = (count_q == CW'(DEPTH));

  AST_BALANCED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> count_q == $past(count_q)); // R8
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_i && !empty_o) |=> head_pid_o == $past(head_pid_o)); // R3
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(1) && pop_i && !push_i) |=> empty_o); // R6
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  localparam int unsigned LW = rn_pkg::idx_bits(NUM_LOG),
  localparam int unsigned PW = rn_pkg::idx_bits(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [LW-1:0] ren_src0,
  input  logic [LW-1:0] ren_src1,
  input  logic          ren_has_dst,
  input  logic [LW-1:0] ren_dst,
  output logic [PW-1:0] ren_psrc0,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_pdst,
  input  logic          free_valid,
  output logic          free_ready,
  input  logic [PW-1:0] free_pid,
  output logic          stall
);
  logic          pool_empty, pool_full;
  logic [PW-1:0] pool_head;
  logic          alloc, release_fire;

  assign stall        = pool_empty;
  assign ren_ready    = !(ren_has_dst && pool_empty);
  assign alloc        = ren_valid && ren_ready && ren_has_dst;
  assign free_ready   = !pool_full;
  assign release_fire = free_valid && free_ready;
  assign ren_pdst     = pool_head;

  rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx0 (ren_src0),
    .rd_idx1 (ren_src1),
    .rd_pid0 (ren_psrc0),
    .rd_pid1 (ren_psrc1),
    .wr_en   (alloc),
    .wr_idx  (ren_dst),
    .wr_pid  (pool_head)
  );

  rn_free_fifo #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_i      (alloc),
    .push_i     (release_fire),
    .push_pid_i (free_pid),
    .head_pid_o (pool_head),
    .empty_o    (pool_empty),
    .full_o     (pool_full)
  );

  AST_STALL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ren_has_dst) |-> !ren_ready); // R6
  AST_READONLY_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_has_dst && !release_fire && !stall) |=> $stable(ren_pdst)); // R9
  AST_READONLY_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_has_dst |-> ren_ready); // R9
endmodule

// File: tb/rn_rename_unit_bench.sv
module rn_rename_unit_bench;
  localparam int NL = 16;
  localparam int NP = 32;
  localparam int LW = $clog2(NL);
  localparam int PW = $clog2(NP);
  localparam int DEPTH = NP - NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_has_dst = 1'b0, free_valid = 1'b0;
  logic [LW-1:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0;
  logic [PW-1:0] free_pid = '0;
  logic ren_ready, free_ready, stall;
  logic [PW-1:0] ren_psrc0, ren_psrc1, ren_pdst;

  always #2 clk = ~clk;  // 250 MHz

  rn_rename_unit #(.NUM_LOG(NL), .NUM_PHYS(NP)) u_rn_rename_unit (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src0(ren_src0), .ren_src1(ren_src1),
    .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
    .ren_psrc0(ren_psrc0), .ren_psrc1(ren_psrc1), .ren_pdst(ren_pdst),
    .free_valid(free_valid), .free_ready(free_ready), .free_pid(free_pid),
    .stall(stall)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int map_m [NL];
  int pool_m [$];
  int pend_m [$];
  int got_s0, got_s1, got_d;
  bit got_rdy;

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // One cycle: drive, sample away from the edge, check, advance the model
  task automatic step(input bit v, input int s0, input int s1, input bit hd,
                      input int d, input bit fv, input int fid);
    bit exp_empty, exp_rdy, exp_frdy;
    @(negedge clk);
    ren_valid = v; ren_src0 = LW'(s0); ren_src1 = LW'(s1);
    ren_has_dst = hd; ren_dst = LW'(d);
    free_valid = fv; free_pid = PW'(fid);
    #1;
    exp_empty = (pool_m.size() == 0);
    exp_rdy   = !(hd && exp_empty);
    exp_frdy  = (pool_m.size() < DEPTH);
    got_s0 = int'(ren_psrc0); got_s1 = int'(ren_psrc1);
    got_d = int'(ren_pdst); got_rdy = ren_ready;
    chk("R6 stall", int'(stall), int'(exp_empty));
    chk("R6 ren_ready", int'(ren_ready), int'(exp_rdy));
    chk("R7 free_ready", int'(free_ready), int'(exp_frdy));
    if (v && exp_rdy) begin
      chk("R2 psrc0", got_s0, map_m[s0]);
      chk("R2 psrc1", got_s1, map_m[s1]);
      if (hd) chk("R3 pdst", got_d, pool_m[0]);
    end
    if (v && exp_rdy && hd) begin
      pend_m.push_back(map_m[d]);
      map_m[d] = pool_m.pop_front();
    end
    if (fv && exp_frdy) pool_m.push_back(fid);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rel;
    void'($urandom(32'd1234));
    for (int k = 0; k < NL; k++) map_m[k] = k;
    for (int k = NL; k < NP; k++) pool_m.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity bindings, read through reading-only renames (R9)
    for (int k = 0; k < NL; k++) begin
      step(1, k, NL - 1 - k, 0, 0, 0, 0);
      chk("R1 reset binding", got_s0, k);
      chk("R9 readonly ready", int'(got_rdy), 1);
    end
    // R1 first pool id, R3 repeated writes to r1, r2, r1 get consecutive ids
    step(1, 0, 0, 1, 1, 0, 0); chk("R1 first pool id", got_d, NL);
    step(1, 0, 0, 1, 2, 0, 0); chk("R3 second alloc", got_d, NL + 1);
    step(1, 0, 0, 1, 1, 0, 0); chk("R3 third alloc", got_d, NL + 2);
    // R4: r1 now bound to the third id
    step(1, 1, 2, 0, 0, 0, 0);
    chk("R4 new binding r1", got_s0, NL + 2);
    chk("R4 new binding r2", got_s1, NL + 1);
    // R5: read and write r4 in one instruction
    step(1, 4, 4, 1, 4, 0, 0);
    chk("R5 source old", got_s0, 4);
    chk("R5 dest new", got_d, NL + 3);
    step(1, 4, 0, 0, 0, 0, 0);
    chk("R4 r4 rebound", got_s0, NL + 3);
    // Drain the pool
    while (pool_m.size() > 0) step(1, 0, 0, 1, 5, 0, 0);
    step(1, 5, 0, 1, 6, 0, 0);
    chk("R6 blocked when empty", int'(got_rdy), 0);
    step(1, 6, 0, 0, 0, 0, 0);
    chk("R6 r6 unchanged", got_s0, 6);
    chk("R9 readonly ready when empty", int'(got_rdy), 1);
    // R8: release into empty pool, then release with allocation together
    rel = pend_m.pop_front();
    step(0, 0, 0, 0, 0, 1, rel);
    begin
      int rel2;
      rel2 = pend_m.pop_front();
      step(1, 0, 0, 1, 7, 1, rel2);
      chk("R8 alloc takes old head", got_d, rel);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R8 released id kept", int'(stall), 0);
      step(1, 7, 0, 1, 8, 0, 0);
      chk("R8 released id reused", got_d, rel2);
      chk("R4 r7 binding", got_s0, rel);
    end
    idle();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v, hd, fv;
      int fid;
      v  = ($urandom % 4) != 0;
      hd = ($urandom % 3) != 0;
      fv = (pend_m.size() > 0) && (($urandom % 2) == 0);
      fid = fv ? pend_m[0] : 0;
      if (fv && pool_m.size() < DEPTH) void'(pend_m.pop_front());
      step(v, $urandom % NL, $urandom % NL, hd, $urandom % NL, fv, fid);
    end
    // Refill completely: R7 full pool refuses releases
    while (pool_m.size() < DEPTH) begin
      fv_fill: begin
        int f;
        f = pend_m.pop_front();
        step(0, 0, 0, 0, 0, 1, f);
      end
    end
    idle();
    chk("R7 full pool", int'(free_ready), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule